// File: doc/BRIEF.md
# Clock Generator Configuration Target (SMBus Indexed Block Access)

This block is the configuration front end of a clock generator. It is a target-only SMBus device that answers at one fixed 7-bit address and keeps a small bank of 8-bit registers. Every access is a block access. A write carries a starting register index, a byte count and then that many data bytes, which land in consecutive registers. A read first sets the starting index with a short write phase. After a repeated start, the target sends a byte count of its own, followed by the register contents from that index onward.

Register 0 drives the clock generator's controls directly: a spread-spectrum enable, a choice between pin-driven and register-driven output enables, a register-driven run/power-down bit, a 4-bit frequency-margin code and the enable of one auxiliary 50 MHz output. The bus lines are sampled by a faster system clock through two-flop synchronizers. The target drives SDA only by pulling it low through an open-drain enable.

Top module: `clkgen_cfg_target`

## Requirements
- R1: The target acknowledges the address byte 0xD2 (write) and 0xD3 (read), which is address 7'b1101001 with the direction bit in bit 0. Any other address byte is not acknowledged, and every later byte is ignored and left unacknowledged until the next start.
- R2: In a write, the target acknowledges the index byte, the count byte N and N data bytes. The data bytes are stored in registers index, index+1, and so on.
- R3: A write count byte of 0 is not acknowledged, and no register changes.
- R4: In a read, after the repeated start and 0xD3, the target sends first a count equal to the number of registers from the index up to the last one (8 minus index by default). It then sends the registers from the index upward, MSB first. After the master's NACK, the target releases SDA.
- R5: An index byte at or beyond the register count (8 by default) is not acknowledged.
- R6: Register 0 maps as follows: bit 7 is the spread enable, bit 6 is the register-driven enable mode, bit 5 is run (1 means outputs on), bits 4..1 are the margin code and bit 0 is the aux 50 MHz enable. Its reset value is 0x21. All other registers reset to 0.
- R7: A start or stop received in the middle of a byte abandons that byte. Bytes that were already complete stay written, and the bus is accepted again at the next start.
- R8: A data byte beyond the announced count, or beyond the last register, is not acknowledged and is not stored.
- R9: A read address (0xD3) that is not preceded by an index in the same transfer is not acknowledged.
- R10: The target begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock line as seen on the bus |
| sda_i | input | 1 | SMBus data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| spread_en_o | output | 1 | Down-spread modulation enable |
| oe_sw_ctrl_o | output | 1 | 0 selects pin-driven enables, 1 selects register-driven enables |
| out_run_o | output | 1 | Register-driven run bit, 0 shuts all outputs |
| margin_sel_o | output | 4 | Frequency margin code |
| aux50_en_o | output | 1 | Auxiliary 50 MHz output enable |

## Verification
A corrupted index or a lost byte counter shows up at the ports at once. The count byte that opens the next read comes back wrong, or the data that follows is shifted by one register. A write that lands in the wrong register changes the control outputs within a clock of the acknowledge. A state machine stuck in the ignore state, or left in a half-received byte, shows up at the very next address byte as a missing ACK. An ACK driven one phase late shows up at the master's sample point in the same bit.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_CNT,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_TXPRE,
    ST_IGN
  } smbt_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA moving while SCL stays high frames a transfer
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbt_reg_bank.sv
module smbt_reg_bank #(
  parameter int         NUM_REGS = 8,
  parameter logic [7:0] CTRL_RST = 8'h21
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] waddr,
  input  logic [7:0] wdata,
  input  logic [7:0] raddr,
  output logic [7:0] rdata,
  output logic [7:0] ctrl_byte
);
  localparam int         AW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regs[i] <= (i == 0) ? CTRL_RST : 8'h00;
      end
    end else if (we) begin
      regs[waddr[AW-1:0]] <= wdata;
    end
  end

  assign rdata     = (raddr < NREG8) ? regs[raddr[AW-1:0]] : 8'hFF;
  assign ctrl_byte = regs[0];

  // R8
  we_range_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr < NREG8));

  // R6
  rst_val_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (regs[0] == CTRL_RST));
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_pull,
  output logic       reg_we,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output logic [7:0] rd_ptr,
  input  logic [7:0] rd_data
);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  smbt_state_e st;
  smbt_state_e nxt_st;
  logic [2:0]  bit_cnt;
  logic [7:0]  rx_sh;
  logic [7:0]  tx_sh;
  logic [7:0]  ptr;
  logic [7:0]  wr_left;
  logic        ofs_ok;
  logic        ack_ph;
  logic [7:0]  rx_byte;

  assign rx_byte = {rx_sh[6:0], sda_s};
  assign rd_ptr  = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      nxt_st    <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      wr_left   <= '0;
      ofs_ok    <= 1'b0;
      ack_ph    <= 1'b0;
      sda_pull  <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        ofs_ok   <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_OFFS, ST_CNT, ST_WDAT: begin
            if (scl_rise) begin
              rx_sh   <= rx_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                ack_ph <= 1'b0;
                st     <= ST_IGN;
                case (st)
                  ST_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR) begin
                      if (!rx_byte[0]) begin
                        st     <= ST_ACK;
                        nxt_st <= ST_OFFS;
                      end else if (ofs_ok) begin
                        st     <= ST_ACK;
                        nxt_st <= ST_TX;
                        tx_sh  <= NREG8 - ptr;
                      end
                    end
                  end
                  ST_OFFS: begin
                    if (rx_byte < NREG8) begin
                      st     <= ST_ACK;
                      nxt_st <= ST_CNT;
                      ptr    <= rx_byte;
                      ofs_ok <= 1'b1;
                    end
                  end
                  ST_CNT: begin
                    if (rx_byte != 8'h00) begin
                      st      <= ST_ACK;
                      nxt_st  <= ST_WDAT;
                      wr_left <= rx_byte;
                    end
                  end
                  ST_WDAT: begin
                    if ((ptr < NREG8) && (wr_left != 8'h00)) begin
                      st        <= ST_ACK;
                      nxt_st    <= (wr_left == 8'h01) ? ST_IGN : ST_WDAT;
                      reg_we    <= 1'b1;
                      reg_waddr <= ptr;
                      reg_wdata <= rx_byte;
                      ptr       <= ptr + 8'h01;
                      wr_left   <= wr_left - 8'h01;
                    end
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_ph) begin
                sda_pull <= 1'b1;
                ack_ph   <= 1'b1;
              end else begin
                ack_ph   <= 1'b0;
                st       <= nxt_st;
                bit_cnt  <= '0;
                sda_pull <= (nxt_st == ST_TX) ? ~tx_sh[7] : 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) st <= ST_MACK;
            end else if (scl_fall) begin
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_pull <= ~tx_sh[6];
            end
          end
          ST_MACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
            end else if (scl_rise) begin
              if (!sda_s) begin
                tx_sh <= rd_data;
                ptr   <= (ptr == 8'hFF) ? ptr : ptr + 8'h01;
                st    <= ST_TXPRE;
              end else begin
                st <= ST_IGN;
              end
            end
          end
          ST_TXPRE: begin
            if (scl_fall) begin
              sda_pull <= ~tx_sh[7];
              bit_cnt  <= '0;
              st       <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  pull_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);

  // R1
  ign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGN && !start_det && !stop_det) |=> (st == ST_IGN));

  // R2
  we_src_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> ($past(st) == ST_WDAT));
endmodule

// File: rtl/clkgen_cfg_target.sv
module clkgen_cfg_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 8,
  parameter logic [7:0] CTRL_RST    = 8'h21,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       spread_en_o,
  output logic       oe_sw_ctrl_o,
  output logic       out_run_o,
  output logic [3:0] margin_sel_o,
  output logic       aux50_en_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       reg_we;
  logic [7:0] reg_waddr, reg_wdata, rd_ptr, rd_data, ctrl_byte;

  smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smbt_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_oe_o),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .rd_ptr    (rd_ptr),
    .rd_data   (rd_data)
  );

  smbt_reg_bank #(.NUM_REGS(NUM_REGS), .CTRL_RST(CTRL_RST)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .waddr     (reg_waddr),
    .wdata     (reg_wdata),
    .raddr     (rd_ptr),
    .rdata     (rd_data),
    .ctrl_byte (ctrl_byte)
  );

  assign spread_en_o  = ctrl_byte[7];
  assign oe_sw_ctrl_o = ctrl_byte[6];
  assign out_run_o    = ctrl_byte[5];
  assign margin_sel_o = ctrl_byte[4:1];
  assign aux50_en_o   = ctrl_byte[0];
endmodule

// File: tb/tb_clkgen_cfg_target.sv
module tb_clkgen_cfg_target;
  localparam int NREG = 8;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_low = 1'b0;
  logic sda_oe, spread_en, oe_sw, run_o, aux_en;
  logic [3:0] margin;
  wire sda_line = ~(sda_low | sda_oe);

  always #5 clk = ~clk;

  clkgen_cfg_target dut (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .spread_en_o  (spread_en),
    .oe_sw_ctrl_o (oe_sw),
    .out_run_o    (run_o),
    .margin_sel_o (margin),
    .aux50_en_o   (aux_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  int r10_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_regs [NREG];
  logic [7:0] wbuf [16];

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl_m) r10_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; scl_m = 1'b1; tick(Q);
    sda_low = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_low = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_low = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_low = ~b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output int acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = (b == 1'b0) ? 1 : 0;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~give_ack);
  endtask

  task automatic do_write(input logic [7:0] ofs, input int n, input string req);
    int a;
    bus_start();
    send_byte(8'hD2, a); chk({req, " addr ack"}, a, 1);
    send_byte(ofs, a);   chk({req, " index ack"}, a, 1);
    send_byte(8'(n), a); chk({req, " count ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk({req, " data ack"}, a, 1);
      exp_regs[int'(ofs) + i] = wbuf[i];
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] ofs, input string req);
    int a;
    logic [7:0] v;
    int cnt;
    cnt = NREG - int'(ofs);
    bus_start();
    send_byte(8'hD2, a); chk({req, " addr ack"}, a, 1);
    send_byte(ofs, a);   chk({req, " index ack"}, a, 1);
    bus_rstart();
    send_byte(8'hD3, a); chk({req, " read addr ack"}, a, 1);
    recv_byte(v, 1'b1);  chk({req, " count byte"}, int'(v), cnt);
    for (int i = 0; i < cnt; i++) begin
      recv_byte(v, (i != cnt - 1));
      chk({req, " data byte"}, int'(v), int'(exp_regs[int'(ofs) + i]));
    end
    tick(2);
    chk({req, " SDA released after NACK"}, int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic chk_ctrl(input string req);
    chk({req, " spread"}, int'(spread_en), int'(exp_regs[0][7]));
    chk({req, " mode"}, int'(oe_sw), int'(exp_regs[0][6]));
    chk({req, " run"}, int'(run_o), int'(exp_regs[0][5]));
    chk({req, " margin"}, int'(margin), int'(exp_regs[0][4:1]));
    chk({req, " aux"}, int'(aux_en), int'(exp_regs[0][0]));
  endtask

  task automatic t_reset();
    chk("R6 reset ctrl byte", int'({spread_en, oe_sw, run_o, margin, aux_en}), 'h21);
    chk("R6 reset SDA idle", int'(sda_oe), 0);
    do_read(8'd0, "R4 R6 reset readback");
  endtask

  task automatic t_ctrl_write();
    wbuf[0] = 8'hC6;
    do_write(8'd0, 1, "R2 ctrl write");
    tick(4);
    chk_ctrl("R6 ctrl fields");
    chk("R6 margin code", int'(margin), 3);
  endtask

  task automatic t_block();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    do_write(8'd2, 3, "R2 block write");
    do_read(8'd2, "R4 block read");
    do_read(8'd7, "R4 last register read");
  endtask

  task automatic t_bad_addr();
    int a;
    bus_start();
    send_byte(8'hA0, a); chk("R1 foreign address nack", a, 0);
    send_byte(8'h00, a); chk("R1 ignored index", a, 0);
    send_byte(8'h01, a); chk("R1 ignored count", a, 0);
    send_byte(8'h00, a); chk("R1 ignored data", a, 0);
    bus_stop();
    tick(4);
    chk_ctrl("R1 ctrl untouched");
  endtask

  task automatic t_zero_cnt();
    int a;
    bus_start();
    send_byte(8'hD2, a); chk("R3 addr ack", a, 1);
    send_byte(8'h00, a); chk("R3 index ack", a, 1);
    send_byte(8'h00, a); chk("R3 zero count nack", a, 0);
    send_byte(8'h00, a); chk("R3 data after zero count", a, 0);
    bus_stop();
    tick(4);
    chk_ctrl("R3 ctrl untouched");
  endtask

  task automatic t_bad_index();
    int a;
    bus_start();
    send_byte(8'hD2, a); chk("R5 addr ack", a, 1);
    send_byte(8'h08, a); chk("R5 index 8 nack", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD2, a); chk("R5 addr ack", a, 1);
    send_byte(8'hFF, a); chk("R5 index FF nack", a, 0);
    bus_stop();
  endtask

  task automatic t_excess();
    int a;
    bus_start();
    send_byte(8'hD2, a); chk("R8 addr ack", a, 1);
    send_byte(8'h06, a); chk("R8 index ack", a, 1);
    send_byte(8'h01, a); chk("R8 count ack", a, 1);
    send_byte(8'h5A, a); chk("R8 data ack", a, 1);
    send_byte(8'h77, a); chk("R8 extra byte nack", a, 0);
    bus_stop();
    exp_regs[6] = 8'h5A;
    bus_start();
    send_byte(8'hD2, a); chk("R8 addr ack", a, 1);
    send_byte(8'h07, a); chk("R8 index ack", a, 1);
    send_byte(8'h03, a); chk("R8 count ack", a, 1);
    send_byte(8'h99, a); chk("R8 last register ack", a, 1);
    send_byte(8'h88, a); chk("R8 past bank nack", a, 0);
    bus_stop();
    exp_regs[7] = 8'h99;
    do_read(8'd6, "R8 readback");
  endtask

  task automatic t_abort();
    int a;
    bus_start();
    send_byte(8'hD2, a); chk("R7 addr ack", a, 1);
    send_byte(8'h00, a); chk("R7 index ack", a, 1);
    send_byte(8'h02, a); chk("R7 count ack", a, 1);
    send_byte(8'h21, a); chk("R7 first data ack", a, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    exp_regs[0] = 8'h21;
    tick(4);
    chk_ctrl("R7 stop mid-byte");
    bus_start();
    send_byte(8'hD2, a); chk("R7 addr ack", a, 1);
    send_byte(8'h04, a); chk("R7 index ack", a, 1);
    send_byte(8'h01, a); chk("R7 count ack", a, 1);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_rstart();
    send_byte(8'hD2, a); chk("R7 recovery addr ack", a, 1);
    send_byte(8'h04, a); chk("R7 recovery index ack", a, 1);
    send_byte(8'h01, a); chk("R7 recovery count ack", a, 1);
    send_byte(8'h3C, a); chk("R7 recovery data ack", a, 1);
    bus_stop();
    exp_regs[4] = 8'h3C;
    do_read(8'd1, "R7 readback");
  endtask

  task automatic t_no_index();
    int a;
    bus_start();
    send_byte(8'hD3, a); chk("R9 read without index nack", a, 0);
    tick(2);
    chk("R9 SDA idle", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_regs[i] = (i == 0) ? 8'h21 : 8'h00;
    tick(5);
    rst = 1'b0;
    tick(10);
    t_reset();
    t_ctrl_write();
    t_block();
    t_bad_addr();
    t_zero_cnt();
    t_bad_index();
    t_excess();
    t_abort();
    t_no_index();
    do_read(8'd0, "R4 final image");
    chk("R10 pull only with SCL low", r10_viol, 0);
    finish_run();
  end
endmodule